// File: doc/BRIEF.md
# Cascadable Four-Bit Carry Chain Adder

This block models the dedicated carry logic found in a programmable logic slice. Every bit position owns a carry multiplexer and an XOR gate. The multiplexer is steered by a per-bit propagate signal. When propagate is high it passes the carry from the bit below. When propagate is low it passes a data bit, the generate term. The XOR gate combines propagate with the carry arriving at that bit to form the sum bit.

The chain is built from four-bit stages. The carry leaving one stage enters the next, so a parameter sets the total width in multiples of four. A front end stands in for the lookup tables that would normally feed the chain. It forms propagate as XOR of the operands for addition and as XNOR for subtraction. In subtract mode it also forces the initial carry to one. The sum, the final carry and the carry arriving at every bit position are registered once and presented together one clock after the operands. The per-bit carries let the chain double as a wide magnitude comparator.

Top module: `carry_chain_adder`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `sum_o`, `cout_o` and `carries_o` become all zero after that edge.
- R2: With `sub_i` = 0, one cycle after the operands are presented, `{cout_o, sum_o}` equals `a_i + b_i + cin_i` computed at width W+1, where W = 4 × NUM_STAGES.
- R3: With `sub_i` = 1, one cycle later `sum_o` equals `a_i - b_i` modulo 2^W. The chain adds `a_i`, the inverse of `b_i` and a forced carry of 1, and `cin_i` has no effect on any output.
- R4: Bit i of `carries_o` is the carry into bit position i, meaning the carry out of the lower i bits of the effective addition. Bit 0 equals the effective carry-in, which is `cin_i` when adding and 1 when subtracting.
- R5: Each carry multiplexer obeys its select. For every position i, the carry out of bit i (`carries_o[i+1]`, or `cout_o` for the top bit) equals the carry into bit i when propagate bit i is 1. It equals `a_i[i]` when propagate bit i is 0. Propagate is `a_i ^ b_i` when adding and `a_i ^ ~b_i` when subtracting. This holds across stage boundaries, so the carry into bit 4k is the carry out of stage k-1.
- R6: Each sum bit equals its propagate bit XOR the carry into that bit: `sum_o[i] = p[i] ^ carries_o[i]`.
- R7: With `sub_i` = 1, `cout_o` is 1 exactly when `a_i` ≥ `b_i` as unsigned numbers, including when they are equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all outputs are registered on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| a_i | input | W | First operand, which is also the generate data of each bit |
| b_i | input | W | Second operand, inverted in subtract mode |
| sub_i | input | 1 | 1 selects subtraction, 0 selects addition |
| cin_i | input | 1 | Carry into bit 0 when adding; unused when subtracting |
| sum_o | output | W | Registered sum or difference |
| cout_o | output | 1 | Registered carry out of the top stage |
| carries_o | output | W | Registered carry into each bit position |

## Verification
The bench instantiates the block with NUM_STAGES = 2, which gives an 8-bit chain of two cascaded stages. At this width every pair of operands can be applied in both addition and subtraction within the cycle budget. That brings every carry pattern into reach, including a carry entering the upper stage from the lower one, the full-length ripple from bit 0 to the carry-out, and the equal-operands edge of the comparison. Dedicated scenarios toggle `cin_i` during subtraction and assert reset in the middle of a run.

// File: rtl/cca_pkg.sv
`timescale 1ns/1ps
package cca_pkg;
    // Bits handled by one carry stage; the chain is built from these.
    localparam int STAGE_W = 4;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;
endpackage

// File: rtl/cca_operand_prep.sv
`timescale 1ns/1ps
// Stand-in for the lookup tables in front of the chain: forms the
// per-bit propagate and generate terms and the effective carry-in.
module cca_operand_prep #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    input  logic         cin_i,
    output logic [W-1:0] prop_o,
    output logic [W-1:0] gen_o,
    output logic         cin_eff_o
);
    import cca_pkg::*;

    op_e op;
    assign op = op_e'(sub_i);

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            always_comb begin
                if (op == OP_SUB) begin
                    prop_o[gi] = ~(a_i[gi] ^ b_i[gi]);
                end else begin
                    prop_o[gi] = a_i[gi] ^ b_i[gi];
                end
                // When propagate is low both operand bits agree, so
                // either one is the carry to generate.
                gen_o[gi] = a_i[gi];
            end
        end
    endgenerate

    always_comb begin
        cin_eff_o = (op == OP_SUB) ? 1'b1 : cin_i;
    end
endmodule

// File: rtl/cca_stage.sv
`timescale 1ns/1ps
// One four-bit stage: a carry multiplexer and an XOR per bit.
module cca_stage #(
    parameter int SW = cca_pkg::STAGE_W
) (
    input  logic [SW-1:0] prop_i,
    input  logic [SW-1:0] gen_i,
    input  logic          ci_i,
    output logic [SW-1:0] sum_o,
    output logic [SW-1:0] cin_bits_o,
    output logic          co_o
);
    logic [SW:0] link;

    assign link[0] = ci_i;

    genvar gi;
    generate
        for (gi = 0; gi < SW; gi++) begin : g_cell
            // Carry multiplexer: select by propagate.
            assign link[gi+1]     = prop_i[gi] ? link[gi] : gen_i[gi];
            // Sum XOR.
            assign sum_o[gi]      = prop_i[gi] ^ link[gi];
            assign cin_bits_o[gi] = link[gi];
        end
    endgenerate

    assign co_o = link[SW];
endmodule

// File: rtl/cca_chain.sv
`timescale 1ns/1ps
// Cascade of stages; each stage's carry-out feeds the next stage.
module cca_chain #(
    parameter int NUM_STAGES = 2,
    localparam int SW = cca_pkg::STAGE_W,
    localparam int W  = NUM_STAGES * SW
) (
    input  logic [W-1:0] prop_i,
    input  logic [W-1:0] gen_i,
    input  logic         ci_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] carries_o,
    output logic         co_o
);
    logic [NUM_STAGES:0] stage_c;

    assign stage_c[0] = ci_i;

    genvar gs;
    generate
        for (gs = 0; gs < NUM_STAGES; gs++) begin : g_stage
            cca_stage #(
                .SW(SW)
            ) u_stage (
                .prop_i     (prop_i[gs*SW +: SW]),
                .gen_i      (gen_i[gs*SW +: SW]),
                .ci_i       (stage_c[gs]),
                .sum_o      (sum_o[gs*SW +: SW]),
                .cin_bits_o (carries_o[gs*SW +: SW]),
                .co_o       (stage_c[gs+1])
            );
        end
    endgenerate

    assign co_o = stage_c[NUM_STAGES];
endmodule

// File: rtl/carry_chain_adder.sv
`timescale 1ns/1ps
module carry_chain_adder #(
    parameter int NUM_STAGES = 2,
    localparam int W = NUM_STAGES * cca_pkg::STAGE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic [W-1:0] carries_o
);
    typedef struct packed {
        logic [W-1:0] sum;
        logic         cout;
        logic [W-1:0] carries;
    } out_t;

    logic [W-1:0] prop;
    logic [W-1:0] gen;
    logic         cin_eff;
    logic [W-1:0] chain_sum;
    logic [W-1:0] chain_carries;
    logic         chain_co;

    out_t out_d;
    out_t out_q;

    cca_operand_prep #(
        .W(W)
    ) u_prep (
        .a_i       (a_i),
        .b_i       (b_i),
        .sub_i     (sub_i),
        .cin_i     (cin_i),
        .prop_o    (prop),
        .gen_o     (gen),
        .cin_eff_o (cin_eff)
    );

    cca_chain #(
        .NUM_STAGES(NUM_STAGES)
    ) u_chain (
        .prop_i    (prop),
        .gen_i     (gen),
        .ci_i      (cin_eff),
        .sum_o     (chain_sum),
        .carries_o (chain_carries),
        .co_o      (chain_co)
    );

    always_comb begin
        out_d.sum     = chain_sum;
        out_d.cout    = chain_co;
        out_d.carries = chain_carries;
        if (!rst_n) begin
            out_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign sum_o     = out_q.sum;
    assign cout_o    = out_q.cout;
    assign carries_o = out_q.carries;
endmodule

// File: rtl/cca_checker.sv
`timescale 1ns/1ps
module cca_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic         sub_i,
    input logic         cin_i,
    input logic [W-1:0] sum_o,
    input logic         cout_o,
    input logic [W-1:0] carries_o
);
    logic [W:0]   add_full;
    logic [W:0]   sub_full;
    logic [W-1:0] p_ref;

    assign add_full = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    assign sub_full = {1'b0, a_i} + {1'b0, ~b_i} + {{W{1'b0}}, 1'b1};
    assign p_ref    = a_i ^ (b_i ^ {W{sub_i}});

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (sum_o == '0 && cout_o == 1'b0 && carries_o == '0));

    assert_add_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !sub_i) |=> ({cout_o, sum_o} == $past(add_full)));

    assert_sub_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && sub_i) |=> ({cout_o, sum_o} == $past(sub_full)));

    assert_first_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (carries_o[0] == $past(sub_i | cin_i)));

    genvar gi;
    generate
        for (gi = 1; gi < W; gi++) begin : g_mux
            assert_mux_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
                rst_n |=> (carries_o[gi] ==
                    ($past(p_ref[gi-1]) ? carries_o[gi-1] : $past(a_i[gi-1]))));
        end
    endgenerate

    assert_top_mux_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (cout_o ==
            ($past(p_ref[W-1]) ? carries_o[W-1] : $past(a_i[W-1]))));

    assert_sum_xor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (sum_o == (carries_o ^ $past(p_ref))));

    assert_compare_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && sub_i) |=> (cout_o == $past(a_i >= b_i)));
endmodule

bind carry_chain_adder cca_checker #(
    .W(W)
) u_cca_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_i       (a_i),
    .b_i       (b_i),
    .sub_i     (sub_i),
    .cin_i     (cin_i),
    .sum_o     (sum_o),
    .cout_o    (cout_o),
    .carries_o (carries_o)
);

// File: tb/test_carry_chain_adder.sv
`timescale 1ns/1ps
module test_carry_chain_adder;
    localparam int NUM_STAGES = 2;
    localparam int W = NUM_STAGES * 4;
    localparam longint unsigned MASK = (64'd1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic         sub_i = 1'b0;
    logic         cin_i = 1'b0;
    logic [W-1:0] sum_o;
    logic         cout_o;
    logic [W-1:0] carries_o;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;  // 125 MHz

    carry_chain_adder #(
        .NUM_STAGES(NUM_STAGES)
    ) i_carry_chain_adder (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_i       (a_i),
        .b_i       (b_i),
        .sub_i     (sub_i),
        .cin_i     (cin_i),
        .sum_o     (sum_o),
        .cout_o    (cout_o),
        .carries_o (carries_o)
    );

    // Reference built from whole-number arithmetic.
    function automatic void model(input logic [W-1:0] a, input logic [W-1:0] b,
                                  input logic sub, input logic cin,
                                  output logic [W-1:0] s, output logic co,
                                  output logic [W-1:0] cv);
        longint unsigned aa = longint'(a);
        longint unsigned bb = sub ? ((~longint'(b)) & MASK) : longint'(b);
        longint unsigned ci = sub ? 64'd1 : longint'(cin);
        longint unsigned tot = aa + bb + ci;
        s  = tot[W-1:0];
        co = tot[W];
        for (int i = 0; i < W; i++) begin
            longint unsigned m  = (64'd1 << i) - 1;
            longint unsigned lo = (aa & m) + (bb & m) + ci;
            cv[i] = lo[i];
        end
    endfunction

    task automatic check(input string req, input string what,
                         input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s a=%0h b=%0h sub=%0b cin=%0b actual=%0h expected=%0h",
                     req, what, a_i, b_i, sub_i, cin_i, act, exp);
        end
    endtask

    // Drive at a falling edge, compare at the next falling edge.
    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic sub, input logic cin, input string req);
        logic [W-1:0] es;
        logic         ec;
        logic [W-1:0] ecv;
        a_i = a; b_i = b; sub_i = sub; cin_i = cin;
        model(a, b, sub, cin, es, ec, ecv);
        @(negedge clk);
        check(req, "sum", longint'(sum_o), longint'(es));
        check(req, "cout", longint'(cout_o), longint'(ec));
        check(req, "carries", longint'(carries_o), longint'(ecv));
    endtask

    task automatic t_reset_state;
        rst_n = 1'b0;
        a_i = '1; b_i = '1; cin_i = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", "sum", longint'(sum_o), 0);
        check("R1", "cout", longint'(cout_o), 0);
        check("R1", "carries", longint'(carries_o), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_add_all;
        // R2 R4 R5 R6: every operand pair, carry-in varied with the operands.
        for (int x = 0; x < (1 << W); x++) begin
            for (int y = 0; y < (1 << W); y++) begin
                apply(x[W-1:0], y[W-1:0], 1'b0, x[0] ^ y[W-1], "R2");
            end
        end
    endtask

    task automatic t_sub_all;
        // R3 R7: every operand pair in subtract mode; cout flags a >= b.
        for (int x = 0; x < (1 << W); x++) begin
            for (int y = 0; y < (1 << W); y++) begin
                apply(x[W-1:0], y[W-1:0], 1'b1, y[0], "R3");
                check("R7", "compare", longint'(cout_o), longint'(x >= y));
            end
        end
    endtask

    task automatic t_full_ripple;
        // R5: carry runs from bit 0 through both stages to the top.
        apply('1, '0, 1'b0, 1'b1, "R5");
        check("R5", "all carries set", longint'(carries_o), MASK);
        check("R5", "ripple cout", longint'(cout_o), 1);
        // Carry generated in the lower stage crosses into the upper one.
        apply(W'(8'h08), W'(8'h08), 1'b0, 1'b0, "R5");
        check("R5", "boundary carry", longint'(carries_o[4]), 1);
        // R4: carry-in alone visible at bit 0.
        apply('0, '0, 1'b0, 1'b1, "R4");
        check("R4", "carry bit 0", longint'(carries_o[0]), 1);
    endtask

    task automatic t_sub_cin_ignored;
        logic [W-1:0] s0;
        logic [W-1:0] c0;
        logic         o0;
        apply(W'(8'h5A), W'(8'h3C), 1'b1, 1'b0, "R3");
        s0 = sum_o; c0 = carries_o; o0 = cout_o;
        apply(W'(8'h5A), W'(8'h3C), 1'b1, 1'b1, "R3");
        check("R3", "cin ignored sum", longint'(sum_o), longint'(s0));
        check("R3", "cin ignored carries", longint'(carries_o), longint'(c0));
        check("R3", "cin ignored cout", longint'(cout_o), longint'(o0));
        apply(W'(8'h77), W'(8'h77), 1'b1, 1'b0, "R7");
        check("R7", "equal operands", longint'(cout_o), 1);
    endtask

    task automatic t_reset_midrun;
        apply('1, '1, 1'b0, 1'b1, "R2");
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "mid-run sum", longint'(sum_o), 0);
        check("R1", "mid-run cout", longint'(cout_o), 0);
        check("R1", "mid-run carries", longint'(carries_o), 0);
        rst_n = 1'b1;
        apply(W'(8'h01), W'(8'h02), 1'b0, 1'b0, "R2");
    endtask

    initial begin
        @(negedge clk);
        t_reset_state();
        t_full_ripple();
        t_sub_cin_ignored();
        t_add_all();
        t_sub_all();
        t_reset_midrun();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 190000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule